// File: doc/BRIEF.md
# I2C Target with Two Masked Addresses

This block is the target side of an I2C link, running entirely in the system clock domain. It samples the SCL and SDA lines, recognises START, repeated START and STOP conditions, and clocks bytes in and out one bit per SCL pulse. The most significant bit comes first, and a ninth acknowledge slot follows every byte. SDA is driven in open-drain fashion: the block only ever asks for the line to be pulled low.

The block compares each incoming address against two programmable addresses. Each address has its own don't-care mask. Comparison uses either the short 7-bit format or the two-byte 10-bit format. Received write bytes are handed to the host as single-cycle strobes. On a read, the block takes each outgoing byte from a host-held input and marks the moment it captured that byte. A 10-bit counter raises a timeout flag when SCL is held low for too long during a transfer.

Top module: `i2c_masked_target`

## Requirements
- R1: A falling SDA while SCL is high starts address reception from any state, and `busy` is high from a START until the next STOP. After reset, `busy` is low and `sda_oe` is low.
- R2: In 7-bit mode (`ten_bit_mode`=0), the first byte after a START carries the address in bits 7..1 and the direction in bit 0, where 1 means read. On a match, the block pulls SDA low (`sda_oe`=1) during the ninth clock. Otherwise it leaves SDA released (NACK) and ignores the bus until the next START or STOP.
- R3: Each address bit whose mask bit is 1 is a don't-care. When both addresses match, address 0 wins, and `match_id` reports the address that matched (0 or 1).
- R4: Every acknowledged full address match produces a one-cycle `match_evt` pulse, even when no data byte follows. A byte that does not match produces no pulse.
- R5: On a write, each data byte is acknowledged and presented on `rx_data` with a one-cycle `rx_valid` strobe. Bytes after a NACKed address produce no strobe.
- R6: On a read, the block captures `tx_data` at the start of each byte and pulses `tx_taken` once per capture. It sends the byte MSB first. After a master ACK it captures the next byte. After a master NACK it keeps SDA released and captures nothing more.
- R7: In 10-bit mode, the first byte must be 11110, then A9, A8, then R/W=0. The block acknowledges it only if A9..A8 can match one of the addresses. The second byte holds A7..A0 and is acknowledged only on a full 10-bit match.
- R8: In 10-bit mode, a header with R/W=1 and the same A9..A8 is acknowledged and starts a read, but only after a full 10-bit match that no STOP has followed. Otherwise the header is NACKed.
- R9: A STOP (SDA rising while SCL is high) at any point returns the block to idle with SDA released, clears the 10-bit selection and clears the timeout counter.
- R10: During a transfer, a 10-bit counter advances each clock while SCL is low and is cleared by every SCL edge and by idle. `tmo_flag` is high while the counter is saturated at 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| slv_addr0 | input | 10 | Address 0 (bits 6..0 used in 7-bit mode) |
| slv_mask0 | input | 10 | Don't-care mask for address 0 |
| slv_addr1 | input | 10 | Address 1 |
| slv_mask1 | input | 10 | Don't-care mask for address 1 |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_data | input | 8 | Byte to send on the next read slot |
| tx_taken | output | 1 | One-cycle strobe when tx_data is captured |
| match_evt | output | 1 | One-cycle pulse on an acknowledged address match |
| match_id | output | 1 | Index of the matched address |
| busy | output | 1 | High between START and STOP |
| tmo_flag | output | 1 | SCL-low timeout reached |

## Verification
The bench probes the masked comparison from both sides. One address is reachable only through its masked bits, and a second case makes both addresses match at once. A design that compared the mask the wrong way round would NACK the first case, and one without priority would report the wrong `match_id`. For 10-bit addressing, the bench issues a read header both after a valid two-byte selection and straight after a STOP. A design that forgot the selection, or kept it across a STOP, acknowledges the wrong one of these. The read path ends with a master NACK, which catches an engine that captures one byte too many or keeps driving SDA. The timeout is sampled just before and well after saturation, so a counter that never runs or never clears fails.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W  = 10;
  localparam int BYTE_W  = 8;
  localparam int N_SLV   = 2;
  localparam int SHORT_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_HDR_ACK, ST_LO, ST_LO_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_HOLD
  } tgt_state_e;

  typedef enum logic [1:0] {CMP_SHORT, CMP_UPPER, CMP_FULL} cmp_sel_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o    = scl_ff[STAGES-1];
  assign sda_o    = sda_ff[STAGES-1];
  assign scl_rise = scl_o & ~scl_q;
  assign scl_fall = ~scl_o & scl_q;
  assign start_o  = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o   = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_tgt_pkg::*;
#(
  parameter int N = N_SLV,
  parameter int W = ADDR_W
) (
  input  logic [N-1:0][W-1:0] addr_i,
  input  logic [N-1:0][W-1:0] mask_i,
  input  logic [W-1:0]        cand_i,
  input  cmp_sel_e            sel_i,
  output logic [N-1:0]        hit_o
);
  localparam logic [W-1:0] SHORT_CARE = W'((1 << SHORT_W) - 1);
  localparam logic [W-1:0] UPPER_CARE = {2'b11, {(W-2){1'b0}}};

  logic [W-1:0] care;

  always_comb begin
    case (sel_i)
      CMP_SHORT: care = SHORT_CARE;
      CMP_UPPER: care = UPPER_CARE;
      default:   care = '1;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit_o[i] = ~|((cand_i ^ addr_i[i]) & ~mask_i[i] & care);
  end
endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                          cnt_d = '0;
    else if (run_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign flag_o = (cnt_q == CNT_MAX);

  assert_tmo_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  assert_tmo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && run_i && !clr_i) |=> flag_o);
endmodule

// File: rtl/i2c_masked_target.sv
module i2c_masked_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] slv_addr0,
  input  logic [ADDR_W-1:0] slv_mask0,
  input  logic [ADDR_W-1:0] slv_addr1,
  input  logic [ADDR_W-1:0] slv_mask1,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_taken,
  output logic              match_evt,
  output logic              match_id,
  output logic              busy,
  output logic              tmo_flag
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shf_q, shf_d, rxd_q, rxd_d;
  logic              oe_q, oe_d, rw_q, rw_d, sel10_q, sel10_d, mack_q, mack_d;
  logic [1:0]        hi_q, hi_d;
  logic              id_q, id_d, evt_q, evt_d, rxv_q, rxv_d, txt_q, txt_d;

  logic [N_SLV-1:0][ADDR_W-1:0] addr_vec, mask_vec;
  logic [ADDR_W-1:0] cand;
  cmp_sel_e          csel;
  logic [N_SLV-1:0]  hit;
  logic              pick;

  assign addr_vec = {slv_addr1, slv_addr0};
  assign mask_vec = {slv_mask1, slv_mask0};

  always_comb begin
    if (state_q == ST_LO) begin
      cand = {hi_q, shf_q};
      csel = CMP_FULL;
    end else if (ten_bit_mode) begin
      cand = {shf_q[2:1], {(ADDR_W-2){1'b0}}};
      csel = CMP_UPPER;
    end else begin
      cand = {{(ADDR_W-SHORT_W){1'b0}}, shf_q[BYTE_W-1:1]};
      csel = CMP_SHORT;
    end
  end

  i2c_addr_cmp #(.N(N_SLV), .W(ADDR_W)) u_cmp (
    .addr_i(addr_vec), .mask_i(mask_vec), .cand_i(cand), .sel_i(csel), .hit_o(hit)
  );

  assign pick = ~hit[0];  // address 0 has priority

  logic byte_end;
  assign byte_end = scl_fall && (bcnt_q == FULL_CNT);

  always_comb begin
    state_d = state_q; bcnt_d = bcnt_q; shf_d = shf_q; rxd_d = rxd_q;
    oe_d = oe_q; rw_d = rw_q; sel10_d = sel10_q; mack_d = mack_q;
    hi_d = hi_q; id_d = id_q;
    evt_d = 1'b0; rxv_d = 1'b0; txt_d = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE; oe_d = 1'b0; sel10_d = 1'b0;
    end else if (start_det) begin
      state_d = ST_HDR; bcnt_d = '0; oe_d = 1'b0;
    end else begin
      // shared receive shifter for address and write bytes
      if ((state_q == ST_HDR || state_q == ST_LO || state_q == ST_WR)
          && scl_rise && bcnt_q != FULL_CNT) begin
        shf_d  = {shf_q[BYTE_W-2:0], sda_s};
        bcnt_d = bcnt_q + 1'b1;
        if (state_q == ST_WR && bcnt_q == LAST_BIT) begin
          rxv_d = 1'b1;
          rxd_d = {shf_q[BYTE_W-2:0], sda_s};
        end
      end

      case (state_q)
        ST_HDR: if (byte_end) begin
          state_d = ST_HOLD;
          if (!ten_bit_mode) begin
            if (|hit) begin
              oe_d = 1'b1; rw_d = shf_q[0]; evt_d = 1'b1; id_d = pick;
              state_d = ST_HDR_ACK;
            end
          end else if (shf_q[7:3] == 5'b11110) begin
            if (!shf_q[0]) begin
              sel10_d = 1'b0;
              if (|hit) begin
                oe_d = 1'b1; rw_d = 1'b0; hi_d = shf_q[2:1]; state_d = ST_HDR_ACK;
              end
            end else if (sel10_q && shf_q[2:1] == hi_q) begin
              oe_d = 1'b1; rw_d = 1'b1; state_d = ST_HDR_ACK;
            end
          end
        end
        ST_HDR_ACK: if (scl_fall) begin
          oe_d = 1'b0; bcnt_d = '0;
          if (rw_q) begin
            state_d = ST_RD; shf_d = tx_data; txt_d = 1'b1; oe_d = ~tx_data[BYTE_W-1];
          end else if (ten_bit_mode) begin
            state_d = ST_LO;
          end else begin
            state_d = ST_WR;
          end
        end
        ST_LO: if (byte_end) begin
          if (|hit) begin
            oe_d = 1'b1; evt_d = 1'b1; id_d = pick; sel10_d = 1'b1; state_d = ST_LO_ACK;
          end else begin
            sel10_d = 1'b0; state_d = ST_HOLD;
          end
        end
        ST_LO_ACK, ST_WR_ACK: if (scl_fall) begin
          oe_d = 1'b0; bcnt_d = '0; state_d = ST_WR;
        end
        ST_WR: if (byte_end) begin
          oe_d = 1'b1; state_d = ST_WR_ACK;
        end
        ST_RD: if (scl_fall) begin
          if (bcnt_q == LAST_BIT) begin
            oe_d = 1'b0; state_d = ST_RD_ACK;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            shf_d  = {shf_q[BYTE_W-2:0], 1'b0};
            oe_d   = ~shf_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = sda_s;
          if (scl_fall) begin
            if (!mack_q) begin
              state_d = ST_RD; bcnt_d = '0; shf_d = tx_data; txt_d = 1'b1;
              oe_d = ~tx_data[BYTE_W-1];
            end else begin
              state_d = ST_HOLD; oe_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE; bcnt_q <= '0; shf_q <= '0; rxd_q <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; sel10_q <= 1'b0; mack_q <= 1'b1;
      hi_q <= '0; id_q <= 1'b0; evt_q <= 1'b0; rxv_q <= 1'b0; txt_q <= 1'b0;
    end else begin
      state_q <= state_d; bcnt_q <= bcnt_d; shf_q <= shf_d; rxd_q <= rxd_d;
      oe_q <= oe_d; rw_q <= rw_d; sel10_q <= sel10_d; mack_q <= mack_d;
      hi_q <= hi_d; id_q <= id_d; evt_q <= evt_d; rxv_q <= rxv_d; txt_q <= txt_d;
    end
  end

  i2c_idle_timer #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_sn),
    .run_i(busy && !scl_s),
    .clr_i(scl_rise || scl_fall || !busy),
    .flag_o(tmo_flag)
  );

  assign busy      = (state_q != ST_IDLE);
  assign sda_oe    = oe_q;
  assign rx_data   = rxd_q;
  assign rx_valid  = rxv_q;
  assign tx_taken  = txt_q;
  assign match_evt = evt_q;
  assign match_id  = id_q;

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_IDLE) |-> !oe_q);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_det |=> (state_q == ST_IDLE));
  assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_det && !stop_det) |=> (state_q == ST_HDR && !oe_q));
  assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_q |=> !evt_q);
  assert_rx_tx_excl_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rxv_q && txt_q));
  assert_nack_hold_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_HOLD) |-> !oe_q);
endmodule

// File: tb/tb_i2c_masked_target.sv
module tb_i2c_masked_target;
  localparam int T = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, ten = 1'b0;
  logic [9:0] a0 = 10'h03A, m0 = 10'h000, a1 = 10'h050, m1 = 10'h003;
  logic [7:0] rx_data, tx_data;
  logic sda_oe, rx_valid, tx_taken, match_evt, match_id, busy, tmo_flag;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, evt_cnt = 0, tx_cnt = 0, rd_idx = 0;
  logic last_id = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] txf(int k);
    return 8'(8'hA7 ^ (k * 8'h35));
  endfunction
  assign tx_data = txf(tx_cnt);

  i2c_masked_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ten_bit_mode(ten), .slv_addr0(a0), .slv_mask0(m0), .slv_addr1(a1), .slv_mask1(m1),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_taken(tx_taken),
    .match_evt(match_evt), .match_id(match_id), .busy(busy), .tmo_flag(tmo_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R5 rx byte", rx_data, e);
      end
    end
    if (tx_taken) tx_cnt++;
    if (match_evt) begin evt_cnt++; last_id = match_id; end
  end

  task automatic wt(); repeat (T) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wt(); scl_m = 1; wt(); sda_m = 0; wt(); scl_m = 0; wt(); endtask
  task automatic bstop();  sda_m = 0; wt(); scl_m = 1; wt(); sda_m = 1; wt(); endtask
  task automatic wbit(input logic b); sda_m = b; wt(); scl_m = 1; wt(); wt(); scl_m = 0; wt(); endtask
  task automatic rbit(output logic b); sda_m = 1; wt(); scl_m = 1; wt(); b = sda_line; wt(); scl_m = 0; wt(); endtask
  task automatic wbyte(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(nack);
  endtask
  task automatic wdata(input logic [7:0] v, input string tag);
    logic n;
    exp_q.push_back(v);
    wbyte(v, n);
    chk(n == 0, tag, n, 0);
  endtask
  task automatic rbyte(input logic mnack, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(mnack);
    chk(v == txf(rd_idx), tag, v, txf(rd_idx));
    rd_idx++;
  endtask

  task automatic report();
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic n;
    int e0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!busy && !sda_oe && !tmo_flag, "R1 reset state", {busy, sda_oe, tmo_flag}, 0);

    // 7-bit write to address 0
    bstart();
    chk(busy, "R1 busy after start", busy, 1);
    wbyte({7'h3A, 1'b0}, n);
    chk(n == 0, "R2 ack exact address", n, 0);
    chk(evt_cnt == 1 && last_id == 0, "R4 match event id0", evt_cnt, 1);
    wdata(8'h96, "R5 ack data 1");
    wdata(8'h01, "R5 ack data 2");
    bstop();
    chk(!busy && !sda_oe, "R9 idle after stop", busy, 0);

    // masked match on address 1
    bstart(); wbyte({7'h52, 1'b0}, n);
    chk(n == 0, "R3 masked ack", n, 0);
    chk(last_id == 1, "R3 id1", last_id, 1);
    wdata(8'h7E, "R5 ack data 3");
    bstop();

    // both addresses match: address 0 wins
    m1 = 10'h07F;
    bstart(); wbyte({7'h3A, 1'b0}, n); bstop();
    chk(n == 0 && last_id == 0, "R3 priority id0", last_id, 0);
    m1 = 10'h003;

    // non-matching address: NACK, data ignored
    e0 = evt_cnt;
    bstart(); wbyte({7'h33, 1'b0}, n);
    chk(n == 1, "R2 nack on miss", n, 1);
    wbyte(8'h55, n);
    chk(n == 1 && evt_cnt == e0, "R4 no event and no ack on miss", evt_cnt, e0);
    bstop();

    // address only
    bstart(); wbyte({7'h3A, 1'b0}, n); bstop();
    chk(evt_cnt == e0 + 1, "R4 event without data", evt_cnt, e0 + 1);

    // 7-bit read: two acked bytes, last NACKed
    bstart(); wbyte({7'h51, 1'b1}, n);
    chk(n == 0, "R2 read address ack", n, 0);
    rbyte(1'b0, "R6 read byte 0");
    rbyte(1'b0, "R6 read byte 1");
    rbyte(1'b1, "R6 read byte 2");
    wt();
    chk(tx_cnt == 3, "R6 capture count", tx_cnt, 3);
    chk(!sda_oe, "R6 released after nack", sda_oe, 0);
    bstop();

    // 10-bit mode
    ten = 1; a0 = 10'h2A5; m0 = 10'h000; a1 = 10'h1F0; m1 = 10'h00F;
    bstart(); wbyte(8'hF4, n);
    chk(n == 0, "R7 header ack", n, 0);
    wbyte(8'hA5, n);
    chk(n == 0 && last_id == 0, "R7 low byte ack id0", n, 0);
    wdata(8'hC8, "R7 10-bit data");
    bstop();

    bstart(); wbyte(8'hF2, n); wbyte(8'hF7, n);
    chk(n == 0 && last_id == 1, "R7 masked 10-bit id1", last_id, 1);
    bstart(); wbyte(8'hF3, n);
    chk(n == 0, "R8 read header after selection", n, 0);
    rbyte(1'b1, "R8 10-bit read byte");
    bstop();

    bstart(); wbyte(8'hF3, n); bstop();
    chk(n == 1, "R8 read header without selection", n, 1);

    bstart(); wbyte(8'hF6, n); bstop();
    chk(n == 1, "R7 upper bits miss", n, 1);

    // timeout
    bstart(); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    repeat (500) @(negedge clk);
    chk(!tmo_flag, "R10 not yet saturated", tmo_flag, 0);
    repeat (700) @(negedge clk);
    chk(tmo_flag, "R10 saturated", tmo_flag, 1);
    bstop();
    chk(!busy && !tmo_flag, "R9 stop mid-byte clears", {busy, tmo_flag}, 0);

    report();
  end
endmodule